// File: doc/BRIEF.md
# Integrating Conversion Sequencer Controller

This controller runs one integrating light-to-count converter that is time-shared across three color channels (red, green, blue). A 3-bit operating mode picks one of three behaviours. The first is idle. The second is a single conversion of one color, after which the controller drops back to idle by itself. The third is back-to-back conversions of one color. The converter front end reaches the block as a pulse stream. The controller counts those pulses over an integration window. The window is the full count of an n-bit counter advanced by an oscillator tick, where n follows the resolution code, so a lower resolution gives a shorter conversion.

At the end of every window, the saturated, right-aligned count is written into the 16-bit result register in a single cycle, and a one-cycle done strobe is raised. A mode write always aborts the window in progress and starts integration from zero. The sensitivity range bit is passed straight through to the front end.

Top module: `conv_seq_ctrl`

## Requirements
- R1: The mode register decodes to a front-end channel: codes 001 and 101 give channel 1 (red), 010 and 110 give channel 2 (blue), 011 and 111 give channel 3 (green). In each of these cases `fe_en_o` is 1 and `fe_chan_o` carries the channel number.
- R2: Mode codes 000 (off) and 100 (reserved) both act as power-down. In power-down, `fe_en_o` and `fe_chan_o` are 0, pulses are ignored, `done_o` stays low and `data_o` holds its value. Reset leaves the mode at 000 and `data_o` at 0.
- R3: The resolution code maps to n as follows: 00 gives 16, 01 gives 12, 10 gives 8 and 11 gives 4. A window lasts exactly 2^n cycles in which `osc_tick_i` is high. `done_o` rises on the clock edge that follows the cycle carrying the window's last tick.
- R4: The resolution code is sampled only when a window starts, which is either a mode write or the end of the previous window. A change of `res_i` during a window does not alter that window's length.
- R5: When a one-shot window (codes 001 to 011) completes, `mode_o` returns to 000 on the same edge that raises `done_o`, and no further conversion follows.
- R6: In continuous modes (codes 101 to 111), the next window starts in the cycle right after the result is latched, and the mode is kept.
- R7: `data_o` equals the number of active cycles in the window that had `pulse_i` high. The value is right-aligned from bit 0, the bits above n are zero, and the value saturates at 2^n-1.
- R8: `data_o` changes only on the edge that raises `done_o`, and all 16 bits change together.
- R9: A mode write (`mode_wr_i` high) aborts the current window with no `done_o`, and clears the pulse and tick counts. Pulses in the write cycle are not counted, and the new window starts in the cycle after the write edge.
- R10: `fe_range_o` follows `range_i` combinationally.
- R11: `done_o` is high for exactly one cycle per completed window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode code to write |
| res_i | input | 2 | Resolution code |
| range_i | input | 1 | Sensitivity range select |
| osc_tick_i | input | 1 | Oscillator tick, advances window |
| pulse_i | input | 1 | Front-end count pulse |
| mode_o | output | 3 | Current mode code |
| fe_en_o | output | 1 | Front end powered |
| fe_chan_o | output | 2 | Selected color channel, 0 when idle |
| fe_range_o | output | 1 | Range to front end |
| data_o | output | 16 | Latched conversion result |
| done_o | output | 1 | One-cycle end-of-conversion strobe |

## Verification
All eight mode codes are swept at 4-bit resolution with pulse periods of 1, 2, 3 and 5. Period 1 exposes saturation, and the other periods separate off-by-one window lengths from miscounted pulses. Single windows at 8, 12 and 16 bits, and a run with the oscillator ticking every third cycle, tell a tick-based window apart from a cycle-based one. Chained continuous windows, a resolution change in mid-window and aborts in the middle of a window check that restarts begin on the right cycle.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    CH_NONE  = 2'd0,
    CH_RED   = 2'd1,
    CH_BLUE  = 2'd2,
    CH_GREEN = 2'd3
  } chan_e;

  typedef struct packed {
    logic  active;
    logic  cont;
    chan_e chan;
  } mode_dec_t;

  localparam logic [2:0] MODE_OFF = 3'b000;
endpackage

// File: rtl/csc_mode_dec.sv
module csc_mode_dec
  import csc_pkg::*;
(
  input  logic [2:0] mode_i,
  output mode_dec_t  dec_o
);
  logic act;

  always_comb begin
    // low bits pick the color; 000 and 100 are both idle
    act          = (mode_i[1:0] != 2'b00);
    dec_o.active = act;
    dec_o.cont   = mode_i[2] & act;
    dec_o.chan   = act ? chan_e'(mode_i[1:0]) : CH_NONE;
  end
endmodule

// File: rtl/csc_win_timer.sv
module csc_win_timer #(
  parameter int DATA_W   = 16,
  parameter int RES_W    = 2,
  parameter int RES_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [RES_W-1:0]  res_i,
  output logic              end_o,
  output logic [DATA_W-1:0] cap_o
);
  localparam int SH_W = $clog2(DATA_W + 1);

  logic [RES_W-1:0]  res_q;
  logic [DATA_W-1:0] cnt_q;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W:0]   full;
  logic [DATA_W:0]   lastv;

  always_comb begin
    shamt = SH_W'(DATA_W - RES_STEP * int'(res_q));
    full  = {{DATA_W{1'b0}}, 1'b1} << shamt;
    lastv = full - 1'b1;
    cap_o = lastv[DATA_W-1:0];
    end_o = run_i && tick_i && !load_i && (cnt_q == cap_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      cnt_q <= '0;
    end else if (load_i || end_o) begin
      // window start: sample resolution, restart count
      res_q <= res_i;
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/csc_pulse_acc.sv
module csc_pulse_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              pulse_i,
  input  logic [DATA_W-1:0] cap_i,
  output logic [DATA_W-1:0] next_o
);
  logic [DATA_W-1:0] acc_q;

  always_comb begin
    next_o = (run_i && pulse_i && (acc_q != cap_i)) ? acc_q + 1'b1 : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clear_i)  acc_q <= '0;
    else if (!run_i)   acc_q <= '0;
    else               acc_q <= next_o;
  end
endmodule

// File: rtl/csc_result_reg.sv
module csc_result_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  localparam int NBYTE = (DATA_W + 7) / 8;

  logic [NBYTE*8-1:0] din_ext;
  logic [NBYTE*8-1:0] data_q;

  assign din_ext = {{(NBYTE*8-DATA_W){1'b0}}, din_i};

  // all byte lanes share one enable so a reader never sees a mixed pair
  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     data_q[b*8 +: 8] <= '0;
      else if (load_i) data_q[b*8 +: 8] <= din_ext[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= load_i;
  end

  assign data_o = data_q[DATA_W-1:0];
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import csc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RES_W    = 2,
  parameter int RES_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [2:0]        mode_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              range_i,
  input  logic              osc_tick_i,
  input  logic              pulse_i,
  output logic [2:0]        mode_o,
  output logic              fe_en_o,
  output logic [1:0]        fe_chan_o,
  output logic              fe_range_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  logic [2:0]        mode_q;
  mode_dec_t         dec;
  logic              win_end;
  logic [DATA_W-1:0] cap;
  logic [DATA_W-1:0] acc_next;

  csc_mode_dec u_dec (
    .mode_i (mode_q),
    .dec_o  (dec)
  );

  csc_win_timer #(
    .DATA_W   (DATA_W),
    .RES_W    (RES_W),
    .RES_STEP (RES_STEP)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mode_wr_i),
    .run_i  (dec.active),
    .tick_i (osc_tick_i),
    .res_i  (res_i),
    .end_o  (win_end),
    .cap_o  (cap)
  );

  csc_pulse_acc #(.DATA_W(DATA_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (mode_wr_i | win_end),
    .run_i   (dec.active),
    .pulse_i (pulse_i),
    .cap_i   (cap),
    .next_o  (acc_next)
  );

  csc_result_reg #(.DATA_W(DATA_W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (win_end),
    .din_i  (acc_next),
    .data_o (data_o),
    .done_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mode_q <= MODE_OFF;
    else if (mode_wr_i)            mode_q <= mode_i;
    else if (win_end && !dec.cont) mode_q <= MODE_OFF;  // one-shot auto power-down
  end

  assign mode_o     = mode_q;
  assign fe_en_o    = dec.active;
  assign fe_chan_o  = dec.chan;
  assign fe_range_o = range_i;
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_wr_i,
  input logic [2:0]        mode_o,
  input logic              fe_en_o,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o
);
  AST_IDLE_NO_FE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1:0] == 2'b00) |-> (!fe_en_o)); // R2
  AST_IDLE_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fe_en_o) |=> (!done_o)); // R2
  AST_ONESHOT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mode_o == 3'b000 || mode_o[2])); // R5
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o) |-> $stable(data_o)); // R8
  AST_ABORT_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> (!done_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o)); // R11
endmodule

bind conv_seq_ctrl csc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_wr_i (mode_wr_i),
  .mode_o    (mode_o),
  .fe_en_o   (fe_en_o),
  .data_o    (data_o),
  .done_o    (done_o)
);

// File: tb/conv_seq_ctrl_tb_top.sv
module conv_seq_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_wr_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  res_i = '0;
  logic        range_i = 1'b0;
  logic        osc_tick_i = 1'b0;
  logic        pulse_i = 1'b0;
  logic [2:0]  mode_o;
  logic        fe_en_o;
  logic [1:0]  fe_chan_o;
  logic        fe_range_o;
  logic [15:0] data_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk_i = ~clk_i;

  conv_seq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .res_i(res_i), .range_i(range_i), .osc_tick_i(osc_tick_i), .pulse_i(pulse_i),
    .mode_o(mode_o), .fe_en_o(fe_en_o), .fe_chan_o(fe_chan_o),
    .fe_range_o(fe_range_o), .data_o(data_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", cyc, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr_mode(input logic [2:0] m, input logic [1:0] r);
    mode_wr_i = 1'b1; mode_i = m; res_i = r; pulse_i = 1'b1; osc_tick_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    mode_wr_i = 1'b0; pulse_i = 1'b0;
  endtask

  task automatic run_win(input int n, input int p, input int d,
                         output int cycles, output int pulses, output int ticks,
                         output bit seen);
    int idx = 0;
    int limit = (1 << n) * d + 4;
    pulses = 0; ticks = 0; seen = 0;
    while (idx < limit) begin
      pulse_i    = ((idx % p) == 0);
      osc_tick_i = ((idx % d) == d - 1);
      if (pulse_i) pulses++;
      if (osc_tick_i) ticks++;
      @(posedge clk_i); @(negedge clk_i);
      idx++;
      if (done_o) begin seen = 1; break; end
    end
    cycles = idx;
    pulse_i = 1'b0; osc_tick_i = 1'b0;
  endtask

  task automatic check_win(input string req, input logic [2:0] m, input int n,
                           input int p, input int d);
    int cy, pu, tk, expd;
    bit seen;
    run_win(n, p, d, cy, pu, tk, seen);
    expd = (pu > (1 << n) - 1) ? (1 << n) - 1 : pu;
    chk(req, "done seen", int'(seen), 1);
    chk("R3", "window cycles", cy, (1 << n) * d);
    chk("R3", "window ticks", tk, 1 << n);
    chk("R7", "result", int'(data_o), expd);
    chk(m[2] ? "R6" : "R5", "mode after", int'(mode_o), m[2] ? int'(m) : 0);
  endtask

  task automatic check_idle(input string req, input int len);
    logic [15:0] held = data_o;
    int dn = 0;
    for (int i = 0; i < len; i++) begin
      pulse_i = 1'b1; osc_tick_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      if (done_o) dn++;
    end
    pulse_i = 1'b0; osc_tick_i = 1'b0;
    chk(req, "idle done count", dn, 0);
    chk(req, "idle fe_en", int'(fe_en_o), 0);
    chk(req, "idle chan", int'(fe_chan_o), 0);
    chk(req, "idle data held", int'(data_o), int'(held));
  endtask

  initial begin
    int pset[4] = '{1, 2, 3, 5};
    repeat (3) @(negedge clk_i);
    chk("R2", "reset mode", int'(mode_o), 0);
    chk("R2", "reset data", int'(data_o), 0);
    chk("R11", "reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep all modes at 4-bit resolution
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 4; k++) begin
        logic [2:0] mm = 3'(m);
        bit act = (mm[1:0] != 2'b00);
        wr_mode(mm, 2'b11);
        chk("R1", "fe_en", int'(fe_en_o), int'(act));
        chk("R1", "chan", int'(fe_chan_o), act ? int'(mm[1:0]) : 0);
        if (act) check_win("R1", mm, 4, pset[k], 1);
        else     check_idle("R2", 20);
      end
    end

    // R5: nothing follows a one-shot
    wr_mode(3'b010, 2'b11);
    check_win("R5", 3'b010, 4, 2, 1);
    check_idle("R5", 40);

    // R10
    range_i = 1'b1; #1;
    chk("R10", "range hi", int'(fe_range_o), 1);
    range_i = 1'b0; #1;
    chk("R10", "range lo", int'(fe_range_o), 0);

    // R3: longer resolutions, R7 saturation at 12 bits
    wr_mode(3'b001, 2'b10);
    check_win("R3", 3'b001, 8, 7, 1);
    wr_mode(3'b010, 2'b01);
    check_win("R7", 3'b010, 12, 1, 1);
    chk("R7", "sat 12b", int'(data_o), 4095);
    wr_mode(3'b011, 2'b00);
    check_win("R3", 3'b011, 16, 3, 1);
    chk("R7", "16b count", int'(data_o), 21846);

    // R3: slow oscillator
    wr_mode(3'b101, 2'b11);
    check_win("R3", 3'b101, 4, 2, 3);

    // R6: chained continuous windows
    wr_mode(3'b111, 2'b11);
    check_win("R6", 3'b111, 4, 1, 1);
    chk("R7", "sat 4b", int'(data_o), 15);
    check_win("R6", 3'b111, 4, 4, 1);
    chk("R6", "second window", int'(data_o), 4);

    // R4: resolution change mid-window only takes effect next window
    wr_mode(3'b110, 2'b11);
    res_i = 2'b10;
    check_win("R4", 3'b110, 4, 3, 1);
    check_win("R4", 3'b110, 8, 3, 1);

    // R9: abort of continuous window, then clean restart
    begin
      int dn = 0;
      wr_mode(3'b101, 2'b11);
      for (int i = 0; i < 7; i++) begin
        pulse_i = 1'b1; osc_tick_i = 1'b1;
        @(posedge clk_i); @(negedge clk_i);
        if (done_o) dn++;
      end
      wr_mode(3'b101, 2'b11);
      chk("R9", "no done on abort", dn + int'(done_o), 0);
      check_win("R9", 3'b101, 4, 2, 1);
      chk("R9", "restart count", int'(data_o), 8);
    end

    // R9: one-shot aborted into power-down
    wr_mode(3'b001, 2'b11);
    repeat (5) begin
      pulse_i = 1'b1; osc_tick_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
    end
    wr_mode(3'b100, 2'b11);
    check_idle("R9", 30);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule